// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns a stream of 10-bit parallel words into a single serial bit stream. It runs on a bit clock that is exactly twelve times the word rate. Every twelve bit-clock cycles it takes one word and sends it as a 12-bit frame. The frame wraps the payload between a leading high clock bit and a trailing low clock bit. The guaranteed rising edge at each frame start lets a receiver recover word timing from the line alone.

A receiver that is not locked needs a pattern it can find easily. When either of two sync request inputs is high at a frame boundary, the block sends that pattern instead of the word: six ones followed by six zeros. A receiver's "not locked" indication can be tied to one of the request inputs. Sync frames then keep flowing until the receiver locks.

All inputs are sampled only at the frame boundary, so a frame is never altered once it has started. A synchronous power-down input holds the line low and rewinds the frame counter. The first frame after power-down begins on the first bit-clock edge after the input is released.

Top module: `ecs_serializer`

## Requirements
- R1: While `rst_n` is low, `ser_out` is 0 and the frame counter is at the boundary position. The first rising edge after reset is released loads a frame.
- R2: In every frame, the first bit on `ser_out` (frame bit 0) is the start clock bit, value 1.
- R3: In a data frame, frame bits 1 through 10 carry `word_in[0]` through `word_in[9]`, least significant bit first.
- R4: In every frame, the last bit (frame bit 11) is the stop clock bit, value 0.
- R5: If `sync_a` is 1 at the boundary, the frame is the sync pattern: frame bits 0 to 5 are 1 and bits 6 to 11 are 0, whatever `word_in` holds.
- R6: If `sync_b` is 1 at the boundary, the frame is the same sync pattern. When both requests are high, the sync pattern is also sent.
- R7: Changes on `word_in`, `sync_a` or `sync_b` after the boundary edge do not affect the frame already being shifted.
- R8: `pwr_dn` high at a rising edge forces `ser_out` to 0 from that edge and resets the frame counter. After `pwr_dn` falls, the next rising edge loads a new frame.
- R9: Frames follow one another with no gaps. Each frame bit lasts one bit-clock cycle, and a new frame starts every 12 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 12x the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Synchronous power-down: output low, counter cleared |
| word_in | input | 10 | Parallel payload word, sampled at the frame boundary |
| sync_a | input | 1 | First sync request |
| sync_b | input | 1 | Second sync request |
| ser_out | output | 1 | Serial line, one frame bit per bit clock |

## Verification
A wrong frame counter shows up at the port within one frame period. A frame becomes longer or shorter than 12 bits, so the next start bit lands one or more cycles away from where a 12-cycle stream expects it. A corrupted shift register or a bad load selection shows up in the very bit where it occurs: the payload bits come out in the wrong order, the clock bits take the wrong value, or a sync frame is mixed with data. An input sampled at the wrong time shows up when inputs change in the middle of a frame: the remaining bits of that frame change. The bench therefore compares whole 12-bit frames captured back to back.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    typedef enum logic {
        FRM_DATA = 1'b0,
        FRM_SYNC = 1'b1
    } frame_kind_e;

    localparam logic START_BIT = 1'b1;
    localparam logic STOP_BIT  = 1'b0;

endpackage

// File: rtl/ecs_bit_counter.sv
module ecs_bit_counter #(
    parameter int FRAME_W = 12,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    output logic [CNT_W-1:0] cnt_o,
    output logic             boundary_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pwr_dn) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o      = st_q.cnt;
    assign boundary_o = (st_q.cnt == '0) && !pwr_dn;

    // R9: the position never leaves the frame
    a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R9: the last position wraps to the boundary
    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn && st_q.cnt == LAST) |=> (st_q.cnt == '0));

    // R8: power-down rewinds the counter
    a_r8_counter_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (st_q.cnt == '0));

endmodule

// File: rtl/ecs_frame_builder.sv
module ecs_frame_builder
    import ecs_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + 2
) (
    input  logic [DATA_W-1:0]  word_i,
    input  logic               sync_a_i,
    input  logic               sync_b_i,
    output logic [FRAME_W-1:0] frame_o
);

    localparam int HALF = FRAME_W / 2;

    logic [FRAME_W-1:0] data_frame;
    logic [FRAME_W-1:0] sync_frame;
    frame_kind_e        kind;

    // data frame: start bit, payload LSB first, stop bit
    assign data_frame[0]         = START_BIT;
    assign data_frame[FRAME_W-1] = STOP_BIT;
    for (genvar i = 0; i < DATA_W; i++) begin : g_payload
        assign data_frame[i+1] = word_i[i];
    end

    // sync frame: first half ones, second half zeros
    for (genvar j = 0; j < FRAME_W; j++) begin : g_sync
        if (j < HALF) begin : g_one
            assign sync_frame[j] = 1'b1;
        end else begin : g_zero
            assign sync_frame[j] = 1'b0;
        end
    end

    assign kind = (sync_a_i || sync_b_i) ? FRM_SYNC : FRM_DATA;

    always_comb begin
        case (kind)
            FRM_SYNC: frame_o = sync_frame;
            default:  frame_o = data_frame;
        endcase
    end

endmodule

// File: rtl/ecs_shifter.sv
module ecs_shifter #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_dn,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               ser_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic               bit_out;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pwr_dn) begin
            st_d.shreg   = '0;
            st_d.bit_out = 1'b0;
        end else if (load_i) begin
            st_d.shreg   = frame_i >> 1;
            st_d.bit_out = frame_i[0];
        end else begin
            st_d.shreg   = st_q.shreg >> 1;
            st_d.bit_out = st_q.shreg[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.bit_out;

    // R8: power-down holds the line low
    a_r8_pwrdn_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !ser_o);

    // R7: between boundaries the frame only advances, never reloads
    a_r7_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn && !load_i) |=> (st_q.shreg == ($past(st_q.shreg) >> 1)));

endmodule

// File: rtl/ecs_serializer.sv
module ecs_serializer #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic [DATA_W-1:0] word_in,
    input  logic              sync_a,
    input  logic              sync_b,
    output logic              ser_out
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   cnt;
    logic               boundary;
    logic [FRAME_W-1:0] frame;

    ecs_bit_counter #(
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .cnt_o      (cnt),
        .boundary_o (boundary)
    );

    ecs_frame_builder #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W)
    ) u_builder (
        .word_i   (word_in),
        .sync_a_i (sync_a),
        .sync_b_i (sync_b),
        .frame_o  (frame)
    );

    ecs_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_dn  (pwr_dn),
        .load_i  (boundary),
        .frame_i (frame),
        .ser_o   (ser_out)
    );

    // R2: a boundary load puts the start bit on the line
    a_r2_start_bit_first: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> ser_out);

    // R4: the last position always drives the stop bit
    a_r4_stop_bit_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn && cnt == LAST) |=> !ser_out);

    // R5 / R6: a sync frame keeps its second bit high
    a_r5_sync_second_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && (sync_a || sync_b)) ##1 !pwr_dn |=> ser_out);

endmodule

// File: tb/ecs_serializer_test.sv
module ecs_serializer_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_dn;
    logic [9:0] word_in;
    logic       sync_a;
    logic       sync_b;
    logic       ser_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ecs_serializer uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_dn  (pwr_dn),
        .word_in (word_in),
        .sync_a  (sync_a),
        .sync_b  (sync_b),
        .ser_out (ser_out)
    );

    // stimulus vectors {sync_a, sync_b, word}
    localparam logic [11:0] VEC [8] = '{
        {2'b00, 10'h000}, {2'b00, 10'h3FF}, {2'b00, 10'h155}, {2'b00, 10'h2AA},
        {2'b10, 10'h123}, {2'b01, 10'h0F0}, {2'b11, 10'h3FF}, {2'b00, 10'h201}
    };

    function automatic logic [11:0] exp_frame(input logic sa, input logic sb, input logic [9:0] w);
        if (sa || sb) return 12'b0000_0011_1111;     // bits 0..5 one (R5, R6)
        return {1'b0, w, 1'b1};                      // stop, payload, start (R2, R3, R4)
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // collects 12 line bits; optionally scrambles the inputs after bit 0
    task automatic collect(output logic [11:0] f, input bit scramble);
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            f[k] = ser_out;
            if (scramble && k == 0) begin
                word_in = ~word_in;
                sync_a  = 1'b1;
                sync_b  = 1'b1;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [11:0] f;
        rst_n   = 1'b0;
        pwr_dn  = 1'b0;
        word_in = '0;
        sync_a  = 1'b0;
        sync_b  = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset line low", {11'b0, ser_out}, 12'b0);

        word_in = VEC[0][9:0];
        sync_a  = VEC[0][11];
        sync_b  = VEC[0][10];
        rst_n   = 1'b1;
        check("R1 idle before first edge", {11'b0, ser_out}, 12'b0);

        // back-to-back frames, inputs set at each boundary (R2 R3 R4 R5 R6 R9)
        for (int i = 0; i < 8; i++) begin
            word_in = VEC[i][9:0];
            sync_a  = VEC[i][11];
            sync_b  = VEC[i][10];
            collect(f, 1'b0);
            if (VEC[i][11] && VEC[i][10]) check("R6 both sync requests R9", f, exp_frame(1'b1, 1'b1, VEC[i][9:0]));
            else if (VEC[i][11])          check("R5 sync_a pattern R9", f, exp_frame(1'b1, 1'b0, VEC[i][9:0]));
            else if (VEC[i][10])          check("R6 sync_b pattern R9", f, exp_frame(1'b0, 1'b1, VEC[i][9:0]));
            else                          check("R2 R3 R4 data frame R9", f, exp_frame(1'b0, 1'b0, VEC[i][9:0]));
        end

        // R7: inputs changed after the boundary leave the frame intact
        word_in = 10'h0C5;
        sync_a  = 1'b0;
        sync_b  = 1'b0;
        collect(f, 1'b1);
        check("R7 mid-frame change ignored", f, exp_frame(1'b0, 1'b0, 10'h0C5));

        // R7: the scrambled inputs (both syncs high) take effect next frame
        collect(f, 1'b0);
        check("R7 new inputs at next boundary", f, exp_frame(1'b1, 1'b1, 10'h33A));

        // R8: power-down in the middle of a frame
        word_in = 10'h3C3;
        sync_a  = 1'b0;
        sync_b  = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        pwr_dn = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R8 line low in power-down", {11'b0, ser_out}, 12'b0);
        end
        word_in = 10'h1A6;
        pwr_dn  = 1'b0;
        collect(f, 1'b0);
        check("R8 fresh frame after power-down", f, exp_frame(1'b0, 1'b0, 10'h1A6));

        // R9: the next frame follows without a gap
        word_in = 10'h2F0;
        collect(f, 1'b0);
        check("R9 continuous after restart", f, exp_frame(1'b0, 1'b0, 10'h2F0));

        // R1: reset in the middle of a frame
        word_in = 10'h3FF;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset clears line", {11'b0, ser_out}, 12'b0);
        @(negedge clk);
        word_in = 10'h00F;
        rst_n   = 1'b1;
        collect(f, 1'b0);
        check("R1 first frame after reset", f, exp_frame(1'b0, 1'b0, 10'h00F));

        finish_run();
    end

endmodule